// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block is the control core of a nonvolatile SRAM model. It sits between a host SRAM port and two word arrays: a working SRAM and a shadow nonvolatile array. It watches a single "supply below threshold" input. When the supply drops, it copies every SRAM word into the shadow array. When the supply comes back, it restores the SRAM from the shadow array. A host request can also start a store, as long as the supply is good.

Both copy engines share one address counter and move one word per clock. A restore always runs in two passes. The first pass writes zero to every SRAM word and the second pass loads each word from the shadow array. While either transfer runs, the block raises a busy flag, drives the host data port to high impedance (output enable low) and ignores all host accesses. Host writes are also dropped whenever the supply is below threshold.

The reset state treats the supply as already low. A good supply seen after reset therefore counts as a power-up and starts a restore.

Top module: `pfail_nvseq`

## Requirements
- R1: A rising `vlow_i` seen while idle starts a store on the next clock. During the store, `nv_we_o` is high for exactly 2^ADDR_W cycles, and afterwards every shadow word equals the SRAM word at the same address.
- R2: A falling `vlow_i` seen while idle starts a restore. Afterwards, every SRAM word equals the shadow word at the same address.
- R3: A restore first writes 0 to SRAM addresses 0 up to 2^ADDR_W-1 in ascending order. It then writes the shadow data to addresses 0 up to 2^ADDR_W-1, again in ascending order.
- R4: A restore never asserts `nv_we_o`, so the shadow array is unchanged by any number of restores.
- R5: While `busy_o` is high, `host_oe_o` stays low, and host writes do not reach the SRAM.
- R6: A host write made while `vlow_i` is high is discarded: the SRAM word keeps its old value.
- R7: A `sw_store_i` pulse starts a store when `vlow_i` is low. The pulse is ignored when `vlow_i` is high: `busy_o` stays low and nothing is written to the shadow array.
- R8: `busy_o` stays high for exactly 2^ADDR_W cycles for a store and 2^(ADDR_W+1) cycles for a restore, clear phase included. `done_o` is a one-cycle pulse in the cycle after the last word of a store and in the cycle after the last word of a restore.
- R9: A supply recovery (falling `vlow_i`) during a store does not cut the store short. The restore starts right after the store, so `busy_o` stays high for 3·2^ADDR_W cycles. If the supply drops again before the store ends, no restore follows.
- R10: Out of reset, `busy_o`, `done_o`, `host_oe_o` and `nv_we_o` are low.
- R11: When idle, a host read (`host_en_i`=1, `host_we_i`=0) raises `host_oe_o` and returns the SRAM word at `host_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vlow_i | input | 1 | Supply below switch threshold |
| host_en_i | input | 1 | Host access enable |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | ADDR_W | Host word address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data |
| host_oe_o | output | 1 | Host data port drive enable (low means high impedance) |
| sw_store_i | input | 1 | Host-requested store pulse |
| busy_o | output | 1 | Store or restore in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_addr_o | output | ADDR_W | SRAM word address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| sram_rdata_i | input | DATA_W | SRAM read data (same cycle) |
| nv_we_o | output | 1 | Shadow array write strobe |
| nv_addr_o | output | ADDR_W | Shadow array word address |
| nv_wdata_o | output | DATA_W | Shadow array write data |
| nv_rdata_i | input | DATA_W | Shadow array read data (same cycle) |

## Verification
Each kind of internal fault shows at the ports in its own way:
- A counter that skips or repeats an address leaves a word uncopied or copied twice. A full read-back sweep after the transfer exposes it.
- A wrong state sequence moves the busy window off its 2^ADDR_W or 2^(ADDR_W+1) cycle count.
- A clear pass that overlaps the load pass puts a nonzero SRAM write inside the first 2^ADDR_W restore writes.
- A lost pending-restore flag ends the busy window at 2^ADDR_W cycles instead of 3·2^ADDR_W, and the SRAM keeps its old contents.

Most of these faults appear within one transfer. The bench sweeps every address of a 16-word configuration, so any single bad word is caught.

// File: rtl/pfail_nvseq.sv
module pfail_nvseq #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vlow_i,
  input  logic              host_en_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_oe_o,
  input  logic              sw_store_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sram_we_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              nv_we_o,
  output logic [ADDR_W-1:0] nv_addr_o,
  output logic [DATA_W-1:0] nv_wdata_o,
  input  logic [DATA_W-1:0] nv_rdata_i
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_CLEAR, S_LOAD} st_t;

  st_t              st;
  logic [ADDR_W-1:0] cnt;
  logic             vlow_q, rec_pend, done_q;
  logic             rise, fall, last, next_pend;

  assign rise      = vlow_i & ~vlow_q;
  assign fall      = ~vlow_i & vlow_q;
  assign last      = (cnt == LAST);
  assign next_pend = fall ? 1'b1 : (rise ? 1'b0 : rec_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      vlow_q   <= 1'b1;
      rec_pend <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      vlow_q <= vlow_i;
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (rise)                       st <= S_STORE;
          else if (fall)                  st <= S_CLEAR;
          else if (sw_store_i && !vlow_i) st <= S_STORE;
        end
        S_STORE: begin
          cnt      <= cnt + 1'b1;
          rec_pend <= next_pend;
          if (last) begin
            done_q   <= 1'b1;
            rec_pend <= 1'b0;
            st       <= next_pend ? S_CLEAR : S_IDLE;
          end
        end
        S_CLEAR: begin
          cnt <= cnt + 1'b1;
          if (last) st <= S_LOAD;
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o       = (st != S_IDLE);
  assign done_o       = done_q;
  assign host_oe_o    = ~busy_o & host_en_i & ~host_we_i;
  assign host_rdata_o = sram_rdata_i;
  assign sram_we_o    = (st == S_CLEAR) | (st == S_LOAD) |
                        (~busy_o & host_en_i & host_we_i & ~vlow_i);
  assign sram_addr_o  = busy_o ? cnt : host_addr_i;
  assign sram_wdata_o = (st == S_LOAD)  ? nv_rdata_i :
                        (st == S_CLEAR) ? '0 : host_wdata_i;
  assign nv_we_o      = (st == S_STORE);
  assign nv_addr_o    = cnt;
  assign nv_wdata_o   = sram_rdata_i;

  a_r1_store_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && vlow_i && !vlow_q) |=> nv_we_o);
  a_r3_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st) != S_LOAD) |-> $past(st) == S_CLEAR);
  a_r4_recall_keeps_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sram_we_o) |-> !nv_we_o);
  a_r6_lowvolt_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    (vlow_i && !busy_o) |-> !sram_we_o);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> cnt == $past(cnt) + 1'b1);
  a_r9_pending_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STORE && last && rec_pend && !vlow_i) |=> st == S_CLEAR);
endmodule

// File: tb/pfail_nvseq_bench.sv
module pfail_nvseq_bench;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, vlow = 1'b1;
  logic hen = 1'b0, hwe = 1'b0, sws = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] hrdata, swdata, srdata, nwdata, nrdata;
  logic hoe, busy, done, swe, nwe;
  logic [AW-1:0] saddr, naddr;

  logic [DW-1:0] sram_m [DEPTH];
  logic [DW-1:0] nv_m [DEPTH];

  int checks = 0, errors = 0;
  int nv_writes = 0;
  int rmon_on = 0, ridx = 0, rbad = 0;

  always #(PERIOD/2) clk = ~clk;

  pfail_nvseq #(.ADDR_W(AW), .DATA_W(DW)) u_pfail_nvseq (
    .clk(clk), .rst_n(rst_n), .vlow_i(vlow),
    .host_en_i(hen), .host_we_i(hwe), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_rdata_o(hrdata), .host_oe_o(hoe), .sw_store_i(sws),
    .busy_o(busy), .done_o(done),
    .sram_we_o(swe), .sram_addr_o(saddr), .sram_wdata_o(swdata), .sram_rdata_i(srdata),
    .nv_we_o(nwe), .nv_addr_o(naddr), .nv_wdata_o(nwdata), .nv_rdata_i(nrdata));

  assign srdata = sram_m[saddr];
  assign nrdata = nv_m[naddr];

  always @(posedge clk) begin
    if (swe) sram_m[saddr] <= swdata;
    if (nwe) begin
      nv_m[naddr] <= nwdata;
      nv_writes <= nv_writes + 1;
    end
    if (rmon_on != 0 && swe) begin
      if (ridx < DEPTH) begin
        if (int'(saddr) != ridx || swdata != '0) rbad <= rbad + 1;
      end else begin
        if (int'(saddr) != ridx - DEPTH || swdata != nv_m[saddr]) rbad <= rbad + 1;
      end
      ridx <= ridx + 1;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a * 37 + k * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_all(input int k, input bit ones);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      hen = 1'b1; hwe = 1'b1; haddr = AW'(a);
      hwdata = ones ? '1 : pat(a, k);
    end
    @(negedge clk);
    hen = 1'b0; hwe = 1'b0;
  endtask

  task automatic read_all(input int k, input string req);
    int bad = 0, first_act = 0, first_exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      hen = 1'b1; hwe = 1'b0; haddr = AW'(a);
      #1;
      if (hrdata != pat(a, k) || hoe != 1'b1) begin
        if (bad == 0) begin first_act = int'(hrdata); first_exp = int'(pat(a, k)); end
        bad++;
      end
    end
    hen = 1'b0;
    chk(bad == 0, req, first_act, first_exp);
  endtask

  function automatic int nv_mismatch(input int k);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) if (nv_m[a] != pat(a, k)) bad++;
    return bad;
  endfunction

  task automatic run_op(input int fall_at, input int rise_at,
                        output int cycles, output int dones, output int oe_bad);
    cycles = 0; dones = 0; oe_bad = 0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      sws = 1'b0;
      if (done) dones++;
      if (!busy) break;
      cycles++;
      if (hoe) oe_bad++;
      hen = 1'b1; hwe = cycles[0]; haddr = AW'(cycles); hwdata = 8'hA5;
      if (cycles == fall_at) vlow = 1'b0;
      if (cycles == rise_at) vlow = 1'b1;
    end
    hen = 1'b0; hwe = 1'b0;
  endtask

  initial begin
    int cyc, dn, oeb, nw0;
    for (int a = 0; a < DEPTH; a++) begin
      nv_m[a] = pat(a, 9);
      sram_m[a] = 8'h55;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 busy/done after reset", int'({busy, done}), 0);
    chk(hoe == 1'b0 && nwe == 1'b0, "R10 oe/nv_we after reset", int'({hoe, nwe}), 0);

    // first power-up restore
    rmon_on = 1; ridx = 0; nw0 = nv_writes;
    vlow = 1'b0;
    run_op(-1, -1, cyc, dn, oeb);
    rmon_on = 0;
    chk(cyc == 2 * DEPTH, "R8 restore busy length", cyc, 2 * DEPTH);
    chk(dn == 1, "R8 restore done pulses", dn, 1);
    chk(rbad == 0 && ridx == 2 * DEPTH, "R3 clear then load order", rbad, 0);
    chk(nv_writes == nw0, "R4 no shadow writes in restore", nv_writes - nw0, 0);
    chk(oeb == 0, "R5 oe low while busy", oeb, 0);
    read_all(9, "R2 restore contents");
    chk(nv_mismatch(9) == 0, "R4 shadow unchanged", nv_mismatch(9), 0);

    // host write/read in idle
    write_all(1, 1'b0);
    read_all(1, "R11 host read back");

    // power-down store
    nw0 = nv_writes;
    vlow = 1'b1;
    run_op(-1, -1, cyc, dn, oeb);
    chk(cyc == DEPTH, "R8 store busy length", cyc, DEPTH);
    chk(dn == 1, "R8 store done pulse", dn, 1);
    chk(nv_writes - nw0 == DEPTH, "R1 store write count", nv_writes - nw0, DEPTH);
    chk(nv_mismatch(1) == 0, "R1 shadow contents", nv_mismatch(1), 0);
    chk(oeb == 0, "R5 oe low during store", oeb, 0);
    read_all(1, "R5 host writes ignored while busy");

    // writes and sw store with supply low
    write_all(0, 1'b1);
    read_all(1, "R6 writes discarded below threshold");
    nw0 = nv_writes;
    @(negedge clk); sws = 1'b1;
    @(negedge clk); sws = 1'b0;
    chk(busy == 1'b0, "R7 sw store rejected busy", int'(busy), 0);
    repeat (DEPTH + 2) @(negedge clk);
    chk(nv_writes == nw0, "R7 sw store rejected writes", nv_writes - nw0, 0);

    // power returns: second restore
    write_all(2, 1'b1);
    rmon_on = 1; ridx = 0; rbad = 0; nw0 = nv_writes;
    vlow = 1'b0;
    run_op(-1, -1, cyc, dn, oeb);
    rmon_on = 0;
    chk(cyc == 2 * DEPTH && rbad == 0, "R3 second restore sequence", rbad, 0);
    chk(nv_writes == nw0, "R4 second restore no shadow writes", nv_writes - nw0, 0);
    read_all(1, "R2 second restore contents");

    // host-requested store with good supply
    write_all(3, 1'b0);
    nw0 = nv_writes;
    @(negedge clk); sws = 1'b1;
    run_op(-1, -1, cyc, dn, oeb);
    chk(cyc == DEPTH, "R7 sw store busy length", cyc, DEPTH);
    chk(nv_mismatch(3) == 0, "R7 sw store contents", nv_mismatch(3), 0);

    // supply returns during store: restore follows
    write_all(4, 1'b0);
    vlow = 1'b1;
    run_op(3, -1, cyc, dn, oeb);
    chk(cyc == 3 * DEPTH, "R9 store then restore busy length", cyc, 3 * DEPTH);
    chk(dn == 2, "R9 two done pulses", dn, 2);
    chk(nv_mismatch(4) == 0, "R9 shadow from store", nv_mismatch(4), 0);
    read_all(4, "R9 sram after chained restore");

    // supply bounces during store: no restore
    write_all(5, 1'b0);
    vlow = 1'b1;
    run_op(2, 5, cyc, dn, oeb);
    chk(cyc == DEPTH, "R9 bounce gives store only", cyc, DEPTH);
    chk(nv_mismatch(5) == 0, "R1 bounce store contents", nv_mismatch(5), 0);
    chk(vlow == 1'b1 && busy == 1'b0, "R9 idle after bounce", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule